// File: doc/BRIEF.md
# Hot-Plug Detect Deglitch Filter

This block cleans up a raw, asynchronous hot-plug detect line before the rest of the chip acts on it. It first brings the line into the system clock domain. Two filter stages then run one after the other. The first is a short glitch rejector whose threshold is counted in single clock cycles. The second is a long validation window whose threshold is counted in units of 1024 cycles. A change reaches the filtered output only if it survives both stages.

The filtered level is presented as a status output. A one-cycle event pulse marks each rising edge and each falling edge of that level. Both thresholds are static configuration inputs. They are only changed while the line is stable. A threshold of zero makes its stage pass a change after a single clock.

The validation stage is a four-state machine. The states are `ST_LOW` (filtered level 0, idle), `ST_RISE_WAIT` (filtered 0, counting a pending high), `ST_HIGH` (filtered 1, idle) and `ST_FALL_WAIT` (filtered 1, counting a pending low). The transitions are:

- LOW→RISE_WAIT when the input goes high and the window is non-zero.
- LOW→HIGH when the input goes high and the window is zero.
- RISE_WAIT→HIGH when the window expires.
- RISE_WAIT→LOW when the input drops back (abort).
- HIGH→FALL_WAIT and HIGH→LOW, the mirror of the two transitions out of LOW.
- FALL_WAIT→LOW when the window expires.
- FALL_WAIT→HIGH when the input returns high (abort).

Top module: `hpd_deglitch`

## Requirements
- R1: After reset the filtered level is 0, both event pulses are 0, and no event is produced for the initial level.
- R2: The raw input passes through a two-flop synchroniser. With both thresholds at 0, a raw change set up before clock edge 1 appears on the filtered level at edge 4.
- R3: A level at the synchroniser output lasting N cycles or fewer, where N is the 4-bit glitch threshold, is discarded. A level lasting N+1 cycles passes the glitch stage.
- R4: A glitch-filtered level lasting M×1024 cycles or fewer, where M is the 12-bit validation threshold, does not change the filtered level. A level lasting M×1024+1 cycles does.
- R5: If the glitch-filtered level returns to the filtered value before the window expires, the validation count restarts from zero at the next change.
- R6: `hpd_rise` is high for exactly one clock, in the cycle where the filtered level has just gone from 0 to 1.
- R7: `hpd_fall` is high for exactly one clock, in the cycle where the filtered level has just gone from 1 to 0.
- R8: For a raw change held long enough, the filtered level changes at clock edge 4+N+M×1024, counting the first edge after the change as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_raw | input | 1 | Raw asynchronous hot-plug detect line |
| glitch_thresh | input | 4 | Glitch threshold N, in cycles |
| valid_thresh | input | 12 | Validation threshold M, in units of 1024 cycles |
| hpd_level | output | 1 | Filtered hot-plug level |
| hpd_rise | output | 1 | One-cycle pulse on a filtered rising edge |
| hpd_fall | output | 1 | One-cycle pulse on a filtered falling edge |

## Verification
The filtered level and its event pulse are due at clock edge 4+N+M×1024 after the raw input changes. That is two synchroniser flops, N+1 glitch-stage cycles, M×1024+1 validation cycles, and no further delay for the output register. Each timing check drives the raw line on a falling edge. It then samples on the falling edge after edge T−1 to confirm nothing has moved yet. It samples again after edge T to confirm the new level and pulse, and once more after edge T+1 to confirm the pulse has cleared. Rejection cases hold the line for exactly the threshold length. They then wait well past the due edge and compare the level and a running count of observed pulses.

// File: rtl/hpd_filt_pkg.sv
`timescale 1ns/1ps
package hpd_filt_pkg;
    typedef enum logic [1:0] {
        ST_LOW       = 2'd0,
        ST_RISE_WAIT = 2'd1,
        ST_HIGH      = 2'd2,
        ST_FALL_WAIT = 2'd3
    } hpd_state_e;
endpackage

// File: rtl/hpd_sync.sv
`timescale 1ns/1ps
module hpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_stage.sv
`timescale 1ns/1ps
module hpd_glitch_stage #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic [CW-1:0] thresh_i,
    output logic          lvl_o
);
    localparam logic [CW-1:0] ONE = 1;

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Accept a new level once it has been seen thresh_i+1 cycles in a row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (lvl_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= thresh_i) begin
            out_q <= lvl_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign lvl_o = out_q;
endmodule

// File: rtl/hpd_valid_fsm.sv
`timescale 1ns/1ps
module hpd_valid_fsm
    import hpd_filt_pkg::*;
#(
    parameter int TW        = 12,
    parameter int UNIT_LOG2 = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic [TW-1:0] thresh_i,
    output logic          level_o,
    output logic          rise_o,
    output logic          fall_o
);
    localparam int CNTW = TW + UNIT_LOG2;
    localparam logic [CNTW-1:0] ONE = 1;

    hpd_state_e     state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [CNTW-1:0] limit;
    logic            next_high;
    logic            level_q, rise_q, fall_q;

    assign limit = {thresh_i, {UNIT_LOG2{1'b0}}};

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOW: begin
                if (lvl_i) begin
                    if (limit == '0) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_RISE_WAIT;
                        cnt_d   = ONE;
                    end
                end
            end
            ST_RISE_WAIT: begin
                if (!lvl_i) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else if (cnt_q >= limit) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_HIGH: begin
                if (!lvl_i) begin
                    if (limit == '0) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_FALL_WAIT;
                        cnt_d   = ONE;
                    end
                end
            end
            ST_FALL_WAIT: begin
                if (lvl_i) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end else if (cnt_q >= limit) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign next_high = (state_d == ST_HIGH) || (state_d == ST_FALL_WAIT);

    // Output register: level and edge pulses move together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            level_q <= next_high;
            rise_q  <= next_high & ~level_q;
            fall_q  <= ~next_high & level_q;
        end
    end

    assign level_o = level_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
endmodule

// File: rtl/hpd_deglitch.sv
`timescale 1ns/1ps
module hpd_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_W    = 4,
    parameter int VALID_W     = 12,
    parameter int UNIT_LOG2   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hpd_raw,
    input  logic [GLITCH_W-1:0] glitch_thresh,
    input  logic [VALID_W-1:0]  valid_thresh,
    output logic                hpd_level,
    output logic                hpd_rise,
    output logic                hpd_fall
);
    logic sync_lvl;
    logic glitch_lvl;

    hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hpd_raw),
        .q_o   (sync_lvl)
    );

    hpd_glitch_stage #(.CW(GLITCH_W)) u_glitch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (sync_lvl),
        .thresh_i (glitch_thresh),
        .lvl_o    (glitch_lvl)
    );

    hpd_valid_fsm #(.TW(VALID_W), .UNIT_LOG2(UNIT_LOG2)) u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (glitch_lvl),
        .thresh_i (valid_thresh),
        .level_o  (hpd_level),
        .rise_o   (hpd_rise),
        .fall_o   (hpd_fall)
    );
endmodule

// File: rtl/hpd_deglitch_chk.sv
`timescale 1ns/1ps
module hpd_deglitch_chk (
    input logic clk,
    input logic rst_n,
    input logic hpd_level,
    input logic hpd_rise,
    input logic hpd_fall
);
    // R6: rising pulse lasts one clock
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_rise |=> !hpd_rise);
    // R6: rising pulse marks a fresh 0->1 of the level
    a_r6_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_rise |-> (hpd_level && !$past(hpd_level)));
    // R7: falling pulse lasts one clock
    a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_fall |=> !hpd_fall);
    // R7: falling pulse marks a fresh 1->0 of the level
    a_r7_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_fall |-> (!hpd_level && $past(hpd_level)));
    // R6/R7: every level change carries its pulse
    a_r7_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_level != $past(hpd_level)) |-> (hpd_rise || hpd_fall));
    // R1: never both pulses at once
    a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hpd_rise, hpd_fall}));
endmodule

bind hpd_deglitch hpd_deglitch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hpd_level (hpd_level),
    .hpd_rise  (hpd_rise),
    .hpd_fall  (hpd_fall)
);

// File: tb/hpd_deglitch_tb.sv
`timescale 1ns/1ps
module hpd_deglitch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hpd_raw = 1'b0;
    logic [3:0]  glitch_thresh = '0;
    logic [11:0] valid_thresh = '0;
    logic        hpd_level, hpd_rise, hpd_fall;

    int errors = 0;
    int checks = 0;
    int rise_seen = 0;
    int fall_seen = 0;

    always #5 clk = ~clk;

    hpd_deglitch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hpd_raw       (hpd_raw),
        .glitch_thresh (glitch_thresh),
        .valid_thresh  (valid_thresh),
        .hpd_level     (hpd_level),
        .hpd_rise      (hpd_rise),
        .hpd_fall      (hpd_fall)
    );

    // Pulses last one clock, so each is seen once at a falling edge
    always @(negedge clk) begin
        if (rst_n && hpd_rise) rise_seen++;
        if (rst_n && hpd_fall) fall_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive raw to v and check the change lands exactly at edge t
    task automatic edge_timing(input string req, input logic v, input int t);
        hpd_raw = v;
        tick(t - 1);
        chk({req, " level before due edge"}, hpd_level, !v);
        chk({req, " no pulse before due edge"}, hpd_rise | hpd_fall, 0);
        tick(1);
        chk({req, " level at due edge"}, hpd_level, v);
        chk({req, " rise pulse at due edge"}, hpd_rise, v);
        chk({req, " fall pulse at due edge"}, hpd_fall, !v);
        tick(1);
        chk({req, " pulse cleared"}, hpd_rise | hpd_fall, 0);
    endtask

    // Hold raw at v for len cycles then return; expect no effect
    task automatic reject(input string req, input logic v, input int len, input int settle);
        int r0, f0;
        r0 = rise_seen;
        f0 = fall_seen;
        hpd_raw = v;
        tick(len);
        hpd_raw = !v;
        tick(settle);
        chk({req, " level unchanged"}, hpd_level, !v);
        chk({req, " no events"}, (rise_seen - r0) + (fall_seen - f0), 0);
    endtask

    task automatic test_reset();
        tick(1);
        chk("R1 level after reset", hpd_level, 0);
        chk("R1 rise after reset", hpd_rise, 0);
        chk("R1 fall after reset", hpd_fall, 0);
        tick(20);
        chk("R1 no event for initial level", rise_seen + fall_seen, 0);
    endtask

    task automatic test_transparent();
        glitch_thresh = 4'd0;
        valid_thresh  = 12'd0;
        edge_timing("R2 R6 rise transparent", 1'b1, 4);
        tick(5);
        edge_timing("R2 R7 fall transparent", 1'b0, 4);
        tick(5);
    endtask

    task automatic test_glitch();
        glitch_thresh = 4'd3;
        valid_thresh  = 12'd0;
        reject("R3 high glitch of N", 1'b1, 3, 20);
        edge_timing("R3 R8 rise at N+1", 1'b1, 7);
        tick(5);
        reject("R3 low glitch of N", 1'b0, 3, 20);
        edge_timing("R3 R7 fall at N+1", 1'b0, 7);
        tick(5);
    endtask

    task automatic test_window();
        glitch_thresh = 4'd0;
        valid_thresh  = 12'd1;
        reject("R4 high for M*1024", 1'b1, 1024, 1100);
        edge_timing("R4 R6 rise at M*1024+1", 1'b1, 1028);
        tick(5);
        reject("R4 low for M*1024", 1'b0, 1024, 1100);
        edge_timing("R4 R7 fall at M*1024+1", 1'b0, 1028);
        tick(5);
    endtask

    task automatic test_restart();
        glitch_thresh = 4'd0;
        valid_thresh  = 12'd1;
        hpd_raw = 1'b1;
        tick(600);
        hpd_raw = 1'b0;
        tick(3);
        chk("R5 no change after partial window", hpd_level, 0);
        edge_timing("R5 count restarts after toggle", 1'b1, 1028);
        tick(5);
        edge_timing("R5 fall after restart case", 1'b0, 1028);
        tick(5);
    endtask

    task automatic test_combined();
        glitch_thresh = 4'd2;
        valid_thresh  = 12'd1;
        edge_timing("R8 combined rise", 1'b1, 1030);
        tick(5);
        edge_timing("R8 combined fall", 1'b0, 1030);
        tick(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        test_reset();
        test_transparent();
        test_glitch();
        test_window();
        test_restart();
        test_combined();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule